// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital half of a successive-approximation analog-to-digital converter. It picks a start-of-conversion source from one of four options. It then walks a trial code from the most significant bit down to bit zero against a one-bit comparator input, and latches the finished code into a high and a low data byte. The code is placed at the right or the left edge of that 16-bit pair. On completion it sets a sticky done flag. When the code lies inside a programmable window it also sets a sticky window flag. Each flag drives an interrupt that has its own enable.

The block also produces the input-multiplexer selection. A channel register picks one of eight external inputs or the internal temperature sensor. A per-pair bit turns two neighbouring external inputs into one differential input. A shutdown bit blocks every start source. Software reaches the block through a byte-wide bus with combinational reads and single-cycle writes. The result width is the parameter `RES_BITS`: 12 by default, 10 for the narrower variant.

Top module: `adcSeqTop`

## Requirements
- R1: A conversion tests one bit per clock, MSB first. The trial code appears on `dacCode`, and bit i is kept when `cmpIn` is 1 while that bit is under trial. With a comparator that reports `dacCode <= vin`, the finished code equals vin, including 0 and the all-ones code.
- R2: CTRL (address 0) bits [5:4] select the start source. 0 is software: a CTRL write with bit 0 set, bits [5:4] = 0 and bit 7 clear. 1 is a `trigTmrA` pulse. 2 is a `trigTmrB` pulse. 3 is a rising edge of `trigExt`. Sources that are not selected have no effect.
- R3: At the end of each conversion the done flag (CTRL bit 2) is set. `doneIrq` equals that flag ANDed with IE (address 3) bit 0.
- R4: The busy flag (CTRL bit 1) rises at the clock edge that takes the start and stays high for exactly `RES_BITS` cycles. A start that arrives while busy is ignored.
- R5: The result is read from DATAH (address 4) and DATAL (address 5). With CTRL bit 6 clear the code is right-justified and the upper bits are zero. With bit 6 set the code is left-justified and the lower bits are zero. The result does not change while busy.
- R6: The window bounds are 16-bit values: the low bound at addresses 6 (low byte) and 7 (high byte), the high bound at 8 and 9. The window flag (CTRL bit 3) is set only when low <= code <= high. `winIrq` equals that flag ANDed with IE bit 1.
- R7: Both flags stay set until a CTRL write carries 0 in the flag's bit position. A write that carries 1 there leaves the flag unchanged.
- R8: CHAN (address 1) bits [3:0] pick the input. Any value of 8 or more selects the temperature sensor: `muxPos`=8, `muxNeg`=15, `diffMode`=0, whatever PAIR holds.
- R9: PAIR (address 2) bit k joins inputs 2k and 2k+1. For a joined pair, `muxPos`=2k, `muxNeg`=2k+1 and `diffMode`=1. Otherwise `muxPos` is the channel, `muxNeg`=15 and `diffMode`=0.
- R10: While CTRL bit 7 (shutdown) is set, no start source starts a conversion.
- R11: After reset every register reads 0, `dacCode` is 0 and both interrupts are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWe | input | 1 | Register write strobe |
| busAddr | input | 4 | Register address |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Combinational read data |
| trigTmrA | input | 1 | First timer overflow pulse |
| trigTmrB | input | 1 | Second timer overflow pulse |
| trigExt | input | 1 | External start, rising-edge sensitive |
| cmpIn | input | 1 | Comparator: 1 when input >= trial level |
| dacCode | output | RES_BITS | Trial code for the feedback DAC |
| muxPos | output | 4 | Positive mux select |
| muxNeg | output | 4 | Negative mux select (15 = ground) |
| diffMode | output | 1 | Differential pair selected |
| doneIrq | output | 1 | Conversion-complete interrupt |
| winIrq | output | 1 | Window interrupt |

## Verification
A start taken at edge P0 sets busy from P0. Bit decisions fall on edges P1 to P`RES_BITS`. The last of these edges clears busy and latches the result and both flags. The bench therefore counts busy at each falling edge from the first one after P0, expects exactly `RES_BITS` high samples, and reads the data registers only after busy has fallen. Register writes and trigger pulses are driven at a falling edge and take effect at the next rising edge. Mux and flag outputs are sampled at the falling edge that follows.

// File: rtl/adcSeqPkg.sv
package adcSeqPkg;
  localparam logic [3:0] ADR_CTRL  = 4'd0;
  localparam logic [3:0] ADR_CHAN  = 4'd1;
  localparam logic [3:0] ADR_PAIR  = 4'd2;
  localparam logic [3:0] ADR_IE    = 4'd3;
  localparam logic [3:0] ADR_DATAH = 4'd4;
  localparam logic [3:0] ADR_DATAL = 4'd5;
  localparam logic [3:0] ADR_WLOL  = 4'd6;
  localparam logic [3:0] ADR_WLOH  = 4'd7;
  localparam logic [3:0] ADR_WHIL  = 4'd8;
  localparam logic [3:0] ADR_WHIH  = 4'd9;

  localparam logic [1:0] SRC_SOFT = 2'd0;
  localparam logic [1:0] SRC_TMRA = 2'd1;
  localparam logic [1:0] SRC_TMRB = 2'd2;
  localparam logic [1:0] SRC_EXT  = 2'd3;

  localparam logic [3:0] MUX_GND  = 4'd15;
  localparam logic [3:0] MUX_TEMP = 4'd8;

  typedef struct packed {
    logic load;
    logic step;
    logic finish;
  } seqStrobe_t;
endpackage

// File: rtl/adcSeqCtrl.sv
module adcSeqCtrl
  import adcSeqPkg::*;
#(
  parameter int RES_BITS = 12,
  parameter int IDX_W = $clog2(RES_BITS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             busWe,
  input  logic [3:0]       busAddr,
  input  logic [7:0]       busWdata,
  input  logic             trigTmrA,
  input  logic             trigTmrB,
  input  logic             trigExt,
  input  logic             winHit,
  input  logic [7:0]       dataHi,
  input  logic [7:0]       dataLo,
  output seqStrobe_t       strobe,
  output logic [IDX_W-1:0] bitIdx,
  output logic [7:0]       busRdata,
  output logic [15:0]      winLo,
  output logic [15:0]      winHi,
  output logic             leftJust,
  output logic             doneIrq,
  output logic             winIrq,
  output logic [3:0]       muxPos,
  output logic [3:0]       muxNeg,
  output logic             diffMode
);
  localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(RES_BITS - 1);

  logic [1:0]       modeQ;
  logic             leftQ, shdnQ, doneQ, winQ, busyQ, extPrevQ;
  logic [3:0]       chanQ, pairQ;
  logic [1:0]       ieQ;
  logic [15:0]      winLoQ, winHiQ;
  logic [IDX_W-1:0] cntQ;

  logic ctrlWr, swStart, hwStart, startGo, lastBit;

  assign ctrlWr  = busWe && (busAddr == ADR_CTRL);
  assign swStart = ctrlWr && busWdata[0] && (busWdata[5:4] == SRC_SOFT) && !busWdata[7];

  always_comb begin
    unique case (modeQ)
      SRC_TMRA: hwStart = trigTmrA;
      SRC_TMRB: hwStart = trigTmrB;
      SRC_EXT:  hwStart = trigExt && !extPrevQ;
      default:  hwStart = 1'b0;
    endcase
  end

  assign startGo = !busyQ && (swStart || (hwStart && !shdnQ));
  assign lastBit = busyQ && (cntQ == '0);

  assign strobe.load   = startGo;
  assign strobe.step   = busyQ;
  assign strobe.finish = lastBit;
  assign bitIdx        = cntQ;

  // sequencer
  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyQ    <= 1'b0;
      cntQ     <= '0;
      extPrevQ <= 1'b0;
    end else begin
      extPrevQ <= trigExt;
      if (startGo) begin
        busyQ <= 1'b1;
        cntQ  <= TOP_IDX;
      end else if (busyQ) begin
        if (lastBit) busyQ <= 1'b0;
        else         cntQ  <= cntQ - 1'b1;
      end
    end
  end

  // register bank
  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeQ  <= SRC_SOFT;
      leftQ  <= 1'b0;
      shdnQ  <= 1'b0;
      chanQ  <= '0;
      pairQ  <= '0;
      ieQ    <= '0;
      winLoQ <= '0;
      winHiQ <= '0;
    end else if (busWe) begin
      unique case (busAddr)
        ADR_CTRL: begin
          modeQ <= busWdata[5:4];
          leftQ <= busWdata[6];
          shdnQ <= busWdata[7];
        end
        ADR_CHAN: chanQ <= busWdata[3:0];
        ADR_PAIR: pairQ <= busWdata[3:0];
        ADR_IE:   ieQ   <= busWdata[1:0];
        ADR_WLOL: winLoQ[7:0]  <= busWdata;
        ADR_WLOH: winLoQ[15:8] <= busWdata;
        ADR_WHIL: winHiQ[7:0]  <= busWdata;
        ADR_WHIH: winHiQ[15:8] <= busWdata;
        default: ;
      endcase
    end
  end

  // sticky flags: setting wins over a clearing write
  always_ff @(posedge clk) begin
    if (!rstN) begin
      doneQ <= 1'b0;
      winQ  <= 1'b0;
    end else begin
      if (lastBit)                     doneQ <= 1'b1;
      else if (ctrlWr && !busWdata[2]) doneQ <= 1'b0;
      if (winHit)                      winQ  <= 1'b1;
      else if (ctrlWr && !busWdata[3]) winQ  <= 1'b0;
    end
  end

  always_comb begin
    unique case (busAddr)
      ADR_CTRL:  busRdata = {shdnQ, leftQ, modeQ, winQ, doneQ, busyQ, 1'b0};
      ADR_CHAN:  busRdata = {4'b0, chanQ};
      ADR_PAIR:  busRdata = {4'b0, pairQ};
      ADR_IE:    busRdata = {6'b0, ieQ};
      ADR_DATAH: busRdata = dataHi;
      ADR_DATAL: busRdata = dataLo;
      ADR_WLOL:  busRdata = winLoQ[7:0];
      ADR_WLOH:  busRdata = winLoQ[15:8];
      ADR_WHIL:  busRdata = winHiQ[7:0];
      ADR_WHIH:  busRdata = winHiQ[15:8];
      default:   busRdata = 8'h00;
    endcase
  end

  // input selection
  always_comb begin
    if (chanQ[3]) begin
      muxPos   = MUX_TEMP;
      muxNeg   = MUX_GND;
      diffMode = 1'b0;
    end else if (pairQ[chanQ[2:1]]) begin
      muxPos   = {1'b0, chanQ[2:1], 1'b0};
      muxNeg   = {1'b0, chanQ[2:1], 1'b1};
      diffMode = 1'b1;
    end else begin
      muxPos   = chanQ;
      muxNeg   = MUX_GND;
      diffMode = 1'b0;
    end
  end

  assign winLo    = winLoQ;
  assign winHi    = winHiQ;
  assign leftJust = leftQ;
  assign doneIrq  = doneQ && ieQ[0];
  assign winIrq   = winQ && ieQ[1];
endmodule

// File: rtl/adcSeqDatapath.sv
module adcSeqDatapath
  import adcSeqPkg::*;
#(
  parameter int RES_BITS = 12,
  parameter int IDX_W = $clog2(RES_BITS)
) (
  input  logic                clk,
  input  logic                rstN,
  input  seqStrobe_t          strobe,
  input  logic [IDX_W-1:0]    bitIdx,
  input  logic                cmpIn,
  input  logic                leftJust,
  input  logic [15:0]         winLo,
  input  logic [15:0]         winHi,
  output logic [RES_BITS-1:0] dacCode,
  output logic [7:0]          dataHi,
  output logic [7:0]          dataLo,
  output logic                winHit
);
  localparam int PAD = 16 - RES_BITS;

  logic [RES_BITS-1:0] sarQ, sarNext, resultQ;
  logic [15:0]         nextWide, outWide;

  always_comb begin
    for (int i = 0; i < RES_BITS; i++) begin
      if (i == int'(bitIdx))          sarNext[i] = cmpIn;
      else if (i + 1 == int'(bitIdx)) sarNext[i] = 1'b1;
      else                            sarNext[i] = sarQ[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sarQ    <= '0;
      resultQ <= '0;
    end else begin
      if (strobe.load)        sarQ <= {1'b1, {(RES_BITS-1){1'b0}}};
      else if (strobe.step)   sarQ <= sarNext;
      if (strobe.finish)      resultQ <= sarNext;
    end
  end

  assign nextWide = 16'(sarNext);
  assign winHit   = strobe.finish && (nextWide >= winLo) && (nextWide <= winHi);

  assign outWide  = leftJust ? (16'(resultQ) << PAD) : 16'(resultQ);
  assign dataHi   = outWide[15:8];
  assign dataLo   = outWide[7:0];
  assign dacCode  = sarQ;
endmodule

// File: rtl/adcSeqTop.sv
module adcSeqTop
  import adcSeqPkg::*;
#(
  parameter int RES_BITS = 12
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                busWe,
  input  logic [3:0]          busAddr,
  input  logic [7:0]          busWdata,
  output logic [7:0]          busRdata,
  input  logic                trigTmrA,
  input  logic                trigTmrB,
  input  logic                trigExt,
  input  logic                cmpIn,
  output logic [RES_BITS-1:0] dacCode,
  output logic [3:0]          muxPos,
  output logic [3:0]          muxNeg,
  output logic                diffMode,
  output logic                doneIrq,
  output logic                winIrq
);
  localparam int IDX_W = $clog2(RES_BITS);

  seqStrobe_t       strobe;
  logic [IDX_W-1:0] bitIdx;
  logic [15:0]      winLo, winHi;
  logic [7:0]       dataHi, dataLo;
  logic             leftJust, winHit;

  adcSeqCtrl #(.RES_BITS(RES_BITS), .IDX_W(IDX_W)) uCtrl (
    .clk(clk), .rstN(rstN), .busWe(busWe), .busAddr(busAddr), .busWdata(busWdata),
    .trigTmrA(trigTmrA), .trigTmrB(trigTmrB), .trigExt(trigExt), .winHit(winHit),
    .dataHi(dataHi), .dataLo(dataLo), .strobe(strobe), .bitIdx(bitIdx),
    .busRdata(busRdata), .winLo(winLo), .winHi(winHi), .leftJust(leftJust),
    .doneIrq(doneIrq), .winIrq(winIrq), .muxPos(muxPos), .muxNeg(muxNeg),
    .diffMode(diffMode)
  );

  adcSeqDatapath #(.RES_BITS(RES_BITS), .IDX_W(IDX_W)) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .bitIdx(bitIdx), .cmpIn(cmpIn),
    .leftJust(leftJust), .winLo(winLo), .winHi(winHi), .dacCode(dacCode),
    .dataHi(dataHi), .dataLo(dataLo), .winHit(winHit)
  );
endmodule

// File: rtl/adcSeqChk.sv
module adcSeqChk #(
  parameter int RES_BITS = 12
) (
  input logic                clk,
  input logic                rstN,
  input logic                busy,
  input logic                shdn,
  input logic                ctrlWr,
  input logic                doneFlag,
  input logic                winFlag,
  input logic [RES_BITS-1:0] resultQ,
  input logic [15:0]         winLo,
  input logic [15:0]         winHi
);
  int busyRun;

  always_ff @(posedge clk) begin
    if (!rstN)     busyRun <= 0;
    else if (busy) busyRun <= busyRun + 1;
    else           busyRun <= 0;
  end

  AST_BUSY_SPAN: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> busyRun < RES_BITS); // R4
  AST_BUSY_FULL: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> $past(busyRun) == RES_BITS - 1); // R1
  AST_DONE_AT_END: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> doneFlag); // R3
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> $stable(resultQ)); // R5
  AST_WIN_INSIDE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(winFlag) |-> (16'(resultQ) >= winLo) && (16'(resultQ) <= winHi)); // R6
  AST_SHDN_NO_START: assert property (@(posedge clk) disable iff (!rstN)
    (shdn && !busy && !ctrlWr) |=> !busy); // R10
endmodule

bind adcSeqTop adcSeqChk #(.RES_BITS(RES_BITS)) uChk (
  .clk(clk), .rstN(rstN), .busy(uCtrl.busyQ), .shdn(uCtrl.shdnQ),
  .ctrlWr(uCtrl.ctrlWr), .doneFlag(uCtrl.doneQ), .winFlag(uCtrl.winQ),
  .resultQ(uDp.resultQ), .winLo(uCtrl.winLoQ), .winHi(uCtrl.winHiQ)
);

// File: tb/test_adcSeqTop.sv
module test_adcSeqTop;
  localparam int CLK_PERIOD = 10;
  localparam int RES = 12;
  localparam int MAXV = (1 << RES) - 1;

  logic           clk = 1'b0;
  logic           rstN = 1'b0;
  logic           busWe = 1'b0;
  logic [3:0]     busAddr = 4'd0;
  logic [7:0]     busWdata = 8'd0;
  logic [7:0]     busRdata;
  logic           trigTmrA = 1'b0, trigTmrB = 1'b0, trigExt = 1'b0;
  logic           cmpIn;
  logic [RES-1:0] dacCode;
  logic [3:0]     muxPos, muxNeg;
  logic           diffMode, doneIrq, winIrq;
  logic [RES-1:0] vin = '0;

  int total = 0;
  int failCnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign cmpIn = (dacCode <= vin);

  adcSeqTop #(.RES_BITS(RES)) i_adcSeqTop (
    .clk(clk), .rstN(rstN), .busWe(busWe), .busAddr(busAddr), .busWdata(busWdata),
    .busRdata(busRdata), .trigTmrA(trigTmrA), .trigTmrB(trigTmrB), .trigExt(trigExt),
    .cmpIn(cmpIn), .dacCode(dacCode), .muxPos(muxPos), .muxNeg(muxNeg),
    .diffMode(diffMode), .doneIrq(doneIrq), .winIrq(winIrq)
  );

  task automatic chk(string req, int act, int exp);
    total++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [7:0] d);
    @(negedge clk);
    busWe = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busWe = 1'b0; busAddr = 4'd0;
  endtask

  task automatic rd(logic [3:0] a, output int v);
    busAddr = a;
    #1;
    v = int'(busRdata);
  endtask

  task automatic pulse(int which);
    @(negedge clk);
    if (which == 1) trigTmrA = 1'b1;
    else if (which == 2) trigTmrB = 1'b1;
    else trigExt = 1'b1;
    @(negedge clk);
    trigTmrA = 1'b0; trigTmrB = 1'b0;
    if (which == 3) trigExt = 1'b0;
  endtask

  // counts busy samples at falling edges until busy drops
  task automatic waitConv(output int cnt);
    int v;
    cnt = 0;
    rd(4'd0, v);
    while (v[1] && cnt < 1000) begin
      cnt++;
      @(negedge clk);
      rd(4'd0, v);
    end
  endtask

  task automatic chkData(string req, int code, bit left);
    int h, l, w;
    w = left ? (code << (16 - RES)) : code;
    rd(4'd4, h);
    rd(4'd5, l);
    chk(req, h, (w >> 8) & 255);
    chk(req, l, w & 255);
  endtask

  task automatic tReset();
    int v;
    for (int a = 0; a < 10; a++) begin
      rd(a[3:0], v);
      chk("R11 reg reset", v, 0);
    end
    chk("R11 dacCode reset", int'(dacCode), 0);
    chk("R11 irq reset", int'({doneIrq, winIrq}), 0);
  endtask

  task automatic tSoftRight();
    int cnt, v;
    wr(4'd3, 8'h01);
    vin = RES'(12'hABC);
    wr(4'd0, 8'h01);
    waitConv(cnt);
    chk("R4 busy length", cnt, RES);
    chkData("R1 R5 right justified", int'(vin), 1'b0);
    rd(4'd0, v);
    chk("R3 done flag", (v >> 2) & 1, 1);
    chk("R3 doneIrq", int'(doneIrq), 1);
    vin = '0;
    wr(4'd0, 8'h01);
    waitConv(cnt);
    chkData("R1 zero code", 0, 1'b0);
    vin = RES'(MAXV);
    wr(4'd0, 8'h01);
    waitConv(cnt);
    chkData("R1 full-scale code", MAXV, 1'b0);
  endtask

  task automatic tLeft();
    int cnt;
    vin = RES'(12'h2D5);
    wr(4'd0, 8'h41);
    waitConv(cnt);
    chkData("R5 left justified", int'(vin), 1'b1);
    wr(4'd0, 8'h00);
    chkData("R5 back to right", int'(vin), 1'b0);
  endtask

  task automatic tSources();
    int cnt, v;
    vin = RES'(12'h155);
    wr(4'd0, 8'h10);
    pulse(2); pulse(3);
    rd(4'd0, v);
    chk("R2 unselected sources ignored", v & 6, 0);
    pulse(1);
    waitConv(cnt);
    chk("R2 timer A start", cnt, RES);
    chkData("R2 timer A data", int'(vin), 1'b0);
    wr(4'd0, 8'h20);
    pulse(1);
    rd(4'd0, v);
    chk("R2 timer A ignored in mode 2", v & 6, 0);
    pulse(2);
    waitConv(cnt);
    chk("R2 timer B start", cnt, RES);
    wr(4'd0, 8'h30);
    wr(4'd0, 8'h31);
    rd(4'd0, v);
    chk("R2 soft start ignored in mode 3", v & 6, 0);
    @(negedge clk); trigExt = 1'b1;
    @(negedge clk);
    waitConv(cnt);
    chk("R2 external edge start", cnt, RES);
    repeat (4) @(negedge clk);
    rd(4'd0, v);
    chk("R2 held external level no restart", v & 2, 0);
    trigExt = 1'b0;
  endtask

  task automatic tBusyIgnore();
    int cnt, v;
    vin = RES'(12'h6A3);
    wr(4'd0, 8'h10);
    pulse(1);
    cnt = 0;
    for (int k = 0; k < RES + 3; k++) begin
      rd(4'd0, v);
      if (v[1]) cnt++;
      trigTmrA = (k == 3);
      @(negedge clk);
    end
    trigTmrA = 1'b0;
    chk("R4 retrigger while busy ignored", cnt, RES);
    chkData("R4 result intact", int'(vin), 1'b0);
  endtask

  task automatic tWindow();
    int cnt, v;
    wr(4'd3, 8'h03);
    wr(4'd6, 8'h00); wr(4'd7, 8'h01);
    wr(4'd8, 8'h00); wr(4'd9, 8'h02);
    vin = RES'(12'h100);
    wr(4'd0, 8'h01);
    waitConv(cnt);
    rd(4'd0, v);
    chk("R6 low bound inclusive", (v >> 3) & 1, 1);
    chk("R6 winIrq", int'(winIrq), 1);
    wr(4'd0, 8'h0C);
    rd(4'd0, v);
    chk("R7 writing ones keeps flags", (v >> 2) & 3, 3);
    wr(4'd0, 8'h08);
    rd(4'd0, v);
    chk("R7 clear done only", (v >> 2) & 3, 2);
    wr(4'd0, 8'h00);
    rd(4'd0, v);
    chk("R7 clear window flag", (v >> 2) & 3, 0);
    chk("R7 irqs low", int'({doneIrq, winIrq}), 0);
    vin = RES'(12'h201);
    wr(4'd0, 8'h01);
    waitConv(cnt);
    rd(4'd0, v);
    chk("R6 above window no flag", (v >> 2) & 3, 1);
    chk("R6 no winIrq outside", int'(winIrq), 0);
    vin = RES'(12'h200);
    wr(4'd0, 8'h01);
    waitConv(cnt);
    rd(4'd0, v);
    chk("R6 high bound inclusive", (v >> 3) & 1, 1);
    wr(4'd0, 8'h00);
    vin = RES'(12'h0FF);
    wr(4'd0, 8'h01);
    waitConv(cnt);
    rd(4'd0, v);
    chk("R6 below window no flag", (v >> 3) & 1, 0);
  endtask

  task automatic tMux();
    wr(4'd1, 8'h05); wr(4'd2, 8'h00);
    @(negedge clk);
    chk("R9 single-ended", int'({diffMode, muxPos, muxNeg}), {1'b0, 4'd5, 4'd15});
    wr(4'd2, 8'h04);
    @(negedge clk);
    chk("R9 differential pair", int'({diffMode, muxPos, muxNeg}), {1'b1, 4'd4, 4'd5});
    wr(4'd1, 8'h08); wr(4'd2, 8'h0F);
    @(negedge clk);
    chk("R8 temperature", int'({diffMode, muxPos, muxNeg}), {1'b0, 4'd8, 4'd15});
    wr(4'd1, 8'h0C);
    @(negedge clk);
    chk("R8 high codes temperature", int'({diffMode, muxPos, muxNeg}), {1'b0, 4'd8, 4'd15});
  endtask

  task automatic tShutdown();
    int cnt, v;
    wr(4'd0, 8'h00);
    wr(4'd0, 8'h90);
    pulse(1);
    rd(4'd0, v);
    chk("R10 timer ignored in shutdown", v & 6, 0);
    wr(4'd0, 8'h81);
    rd(4'd0, v);
    chk("R10 soft start ignored in shutdown", v & 6, 0);
    wr(4'd0, 8'h10);
    vin = RES'(12'h3C7);
    pulse(1);
    waitConv(cnt);
    chk("R10 runs after shutdown cleared", cnt, RES);
    chkData("R10 data after wake", int'(vin), 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tSoftRight();
    tLeft();
    tSources();
    tBusyIgnore();
    tWindow();
    tMux();
    tShutdown();
    $display("%0d/%0d checks passed", total - failCnt, total);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    total++; failCnt++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - failCnt, total);
    $finish;
  end
endmodule